// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Register

This block keeps the eight-bit status byte of a serial flash device and decides whether a program or erase may touch a given address. A command decoder upstream presents one strobe per completed instruction, together with a small instruction code. The operation timer reports when it is busy, when a program or erase has finished, and when auto-increment programming has run off the top of the array. The block also watches the write-protect pin level.

It returns the status byte that a read-status instruction shifts out. It also returns a combinational permit flag for the address and operation kind the sequencer presents, and the current auto-increment mode. Protection covers the top quarter, the top half or the whole array. The boundaries are derived from the address-width parameter. Sector and block erases are judged over their whole aligned span.

Top module: `flash_status_guard`

## Requirements
- R1: `status_o` holds BUSY at bit 0, WEL at bit 1, BP0 at bit 2, BP1 at bit 3, zeros at bits 5:4, AAI mode at bit 6 and BPL at bit 7. A status write changes only bits 7, 3 and 2.
- R2: A synchronous reset leaves BP1:BP0 = 11 and WEL, AAI and BPL at 0, so `status_o` reads 0x0C while idle.
- R3: Instruction codes on `instr_code_i` are 0 other, 1 write-enable, 2 write-disable, 3 enable-status-write, 4 status-write and 5 auto-increment begin. A status write (4) takes effect only when the instruction strobe just before it carried code 3. Any other instruction in between wastes the arming.
- R4: An armed status write is rejected while `wp_n_i` is low and BPL is 1. With `wp_n_i` high, BPL, BP1 and BP0 are all writable, and BPL may return to 0.
- R5: With `wp_n_i` low and BPL at 0, one armed status write can set BPL and change BP1:BP0 together.
- R6: With WEL at 1 and not busy, a program (`chk_op_i` = 0) is permitted unless its address is at or above the floor of the protected region. The floor is the array size for BP 00, three quarters of it for 01, half of it for 10 and zero for 11.
- R7: A sector erase (`chk_op_i` = 1, 2^SECTOR_W bytes) or block erase (2, 2^BLOCK_W bytes) is permitted only if the last byte of its aligned span lies below the floor.
- R8: A chip erase (`chk_op_i` = 3) is permitted only when BP1 and BP0 are both 0, WEL is 1 and the device is not busy.
- R9: Write-enable sets WEL. Write-disable and `op_done_i` clear it.
- R10: Auto-increment begin sets AAI mode only when WEL is 1 and `chk_addr_i` is not protected. Write-disable clears AAI mode. `aai_end_i` clears both AAI mode and WEL.
- R11: BUSY follows `busy_i` and cannot be changed by a status write. While busy, the permit flag is 0.
- R12: When a completion pulse and an instruction strobe fall in the same cycle, the completion clears are applied first and the instruction's own effect is applied on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_stb_i | input | 1 | One-cycle pulse per decoded instruction |
| instr_code_i | input | 3 | Instruction kind (see R3) |
| wrsr_data_i | input | 8 | Data byte of a status write |
| op_done_i | input | 1 | Byte program or erase finished |
| aai_end_i | input | 1 | Auto-increment programming reached the top address |
| busy_i | input | 1 | Internal operation in progress |
| wp_n_i | input | 1 | Write-protect pin level, low asserts protection of the lock |
| chk_addr_i | input | ADDR_W | Address under test |
| chk_op_i | input | 2 | Operation under test (see R6 to R8) |
| status_o | output | 8 | Status byte |
| write_ok_o | output | 1 | Operation at address is permitted |
| aai_mode_o | output | 1 | Auto-increment mode flag |

## Verification
A completion pulse from the operation timer can land in the same cycle as a decoded instruction. The bench provokes this twice. It sends write-enable together with `op_done_i` and expects WEL to stay set. It then sends auto-increment begin together with `aai_end_i` and expects AAI mode set with WEL cleared. A second overlap is the write-protect pin changing around an armed status write. The bench holds the pin low across a lock-and-change write, then across a rejected write, and then releases the pin to clear the lock. Each step is judged on the returned status byte and permit flag.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [2:0] {
        INS_OTHER     = 3'd0,
        INS_WREN      = 3'd1,
        INS_WRDI      = 3'd2,
        INS_EWSR      = 3'd3,
        INS_WRSR      = 3'd4,
        INS_AAI_BEGIN = 3'd5
    } instr_e;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SECTOR = 2'd1,
        OP_BLOCK  = 2'd2,
        OP_CHIP   = 2'd3
    } op_e;

    // Protection fields that a status write can alter
    typedef struct packed {
        logic       lock;
        logic [1:0] level;
    } guard_t;

    // Software-visible state held in flops
    typedef struct packed {
        guard_t guard;
        logic   wel;
        logic   aai;
    } sr_state_t;

    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_BP0  = 2;
    localparam int BIT_BP1  = 3;
    localparam int BIT_AAI  = 6;
    localparam int BIT_BPL  = 7;

    localparam logic [1:0] LEVEL_AT_RESET = 2'b11;

    function automatic logic [7:0] pack_status(sr_state_t s, logic busy);
        logic [7:0] b;
        b           = 8'h00;
        b[BIT_BUSY] = busy;
        b[BIT_WEL]  = s.wel;
        b[BIT_BP0]  = s.guard.level[0];
        b[BIT_BP1]  = s.guard.level[1];
        b[BIT_AAI]  = s.aai;
        b[BIT_BPL]  = s.guard.lock;
        return b;
    endfunction

    function automatic guard_t unpack_guard(logic [7:0] d);
        guard_t g;
        g.lock     = d[BIT_BPL];
        g.level[1] = d[BIT_BP1];
        g.level[0] = d[BIT_BP0];
        return g;
    endfunction

    // Lowest protected address for a protection level in an array of 2^aw bytes
    function automatic logic [31:0] region_floor(logic [1:0] level, int unsigned aw);
        logic [31:0] full;
        full = 32'd1 << aw;
        case (level)
            2'b00:   return full;
            2'b01:   return full - (full >> 2);
            2'b10:   return full >> 1;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/fsr_arm_track.sv
module fsr_arm_track
    import flash_sr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   instr_stb,
    input  instr_e instr_code,
    output logic   armed
);

    logic armed_q;

    // Armed only by the most recent instruction being the enabling one
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (instr_stb) begin
            armed_q <= (instr_code == INS_EWSR);
        end
    end

    assign armed = armed_q;

    p_arm_waste_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_stb && instr_code != INS_EWSR) |=> !armed);

    p_arm_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !instr_stb |=> $stable(armed));

endmodule

// File: rtl/fsr_range_check.sv
module fsr_range_check
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SECTOR_W = 12,
    parameter int BLOCK_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        level,
    input  logic              wel,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  op_e               op,
    output logic              op_ok,
    output logic              start_clear
);

    localparam logic [ADDR_W-1:0] SECTOR_MASK = ADDR_W'((64'd1 << SECTOR_W) - 64'd1);
    localparam logic [ADDR_W-1:0] BLOCK_MASK  = ADDR_W'((64'd1 << BLOCK_W) - 64'd1);

    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] span_end;
    logic [31:0]       floor_addr;
    logic              span_clear;
    logic              chip_clear;

    always_comb begin
        case (op)
            OP_SECTOR: span_mask = SECTOR_MASK;
            OP_BLOCK:  span_mask = BLOCK_MASK;
            default:   span_mask = '0;
        endcase
    end

    assign span_end    = addr | span_mask;
    assign floor_addr  = region_floor(level, ADDR_W);
    assign span_clear  = (32'(span_end) < floor_addr);
    assign start_clear = (32'(addr) < floor_addr);
    assign chip_clear  = (level == 2'b00);

    always_comb begin
        if (!wel || busy) begin
            op_ok = 1'b0;
        end else if (op == OP_CHIP) begin
            op_ok = chip_clear;
        end else begin
            op_ok = span_clear;
        end
    end

    p_chip_guard_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CHIP && level != 2'b00) |-> !op_ok);

    p_full_guard_r6: assert property (@(posedge clk) disable iff (rst)
        (level == 2'b11) |-> (!op_ok && !start_clear));

endmodule

// File: rtl/fsr_state_regs.sv
module fsr_state_regs
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_stb,
    input  instr_e     instr_code,
    input  logic [7:0] wrsr_data,
    input  logic       armed,
    input  logic       wp_n,
    input  logic       op_done,
    input  logic       aai_end,
    input  logic       start_clear,
    output sr_state_t  state
);

    sr_state_t cur_q;
    sr_state_t nxt;
    logic      lock_open;

    assign lock_open = wp_n || !cur_q.guard.lock;

    always_comb begin
        nxt = cur_q;
        // completion clears first, instruction effect on top
        if (op_done) begin
            nxt.wel = 1'b0;
        end
        if (aai_end) begin
            nxt.wel = 1'b0;
            nxt.aai = 1'b0;
        end
        if (instr_stb) begin
            case (instr_code)
                INS_WREN: nxt.wel = 1'b1;
                INS_WRDI: begin
                    nxt.wel = 1'b0;
                    nxt.aai = 1'b0;
                end
                INS_WRSR: begin
                    if (armed && lock_open) begin
                        nxt.guard = unpack_guard(wrsr_data);
                    end
                end
                INS_AAI_BEGIN: begin
                    if (cur_q.wel && start_clear) begin
                        nxt.aai = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.guard.lock  <= 1'b0;
            cur_q.guard.level <= LEVEL_AT_RESET;
            cur_q.wel         <= 1'b0;
            cur_q.aai         <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign state = cur_q;

    p_unarmed_wrsr_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_stb && instr_code == INS_WRSR && !armed) |=> $stable(state.guard));

    p_lock_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state.guard.lock && !wp_n) |=> state.guard.lock);

    p_wel_done_r9: assert property (@(posedge clk) disable iff (rst)
        (op_done && !(instr_stb && instr_code == INS_WREN)) |=> !state.wel);

    p_wrdi_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (instr_stb && instr_code == INS_WRDI) |=> (!state.aai && !state.wel));

    p_aai_needs_wel_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(state.aai) |-> $past(state.wel));

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SECTOR_W = 12,
    parameter int BLOCK_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_stb_i,
    input  logic [2:0]        instr_code_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              op_done_i,
    input  logic              aai_end_i,
    input  logic              busy_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic [1:0]        chk_op_i,
    output logic [7:0]        status_o,
    output logic              write_ok_o,
    output logic              aai_mode_o
);

    instr_e    code;
    op_e       op;
    logic      armed;
    logic      start_clear;
    sr_state_t state;

    assign code = instr_e'(instr_code_i);
    assign op   = op_e'(chk_op_i);

    fsr_arm_track u_arm (
        .clk        (clk),
        .rst        (rst),
        .instr_stb  (instr_stb_i),
        .instr_code (code),
        .armed      (armed)
    );

    fsr_state_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .instr_stb   (instr_stb_i),
        .instr_code  (code),
        .wrsr_data   (wrsr_data_i),
        .armed       (armed),
        .wp_n        (wp_n_i),
        .op_done     (op_done_i),
        .aai_end     (aai_end_i),
        .start_clear (start_clear),
        .state       (state)
    );

    fsr_range_check #(
        .ADDR_W   (ADDR_W),
        .SECTOR_W (SECTOR_W),
        .BLOCK_W  (BLOCK_W)
    ) u_range (
        .clk         (clk),
        .rst         (rst),
        .level       (state.guard.level),
        .wel         (state.wel),
        .busy        (busy_i),
        .addr        (chk_addr_i),
        .op          (op),
        .op_ok       (write_ok_o),
        .start_clear (start_clear)
    );

    assign status_o   = pack_status(state, busy_i);
    assign aai_mode_o = state.aai;

    p_ok_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
        write_ok_o |-> (status_o[BIT_WEL] && !busy_i));

    p_reserved_low_r1: assert property (@(posedge clk) disable iff (rst)
        status_o[5:4] == 2'b00);

endmodule

// File: tb/sim_flash_status_guard.sv
module sim_flash_status_guard;

    typedef struct packed {
        logic        stb;
        logic [2:0]  code;
        logic [7:0]  data;
        logic        done;
        logic        aend;
        logic        wp_n;
        logic        busy;
        logic [18:0] addr;
        logic [1:0]  op;
        logic [7:0]  exp_st;
        logic        exp_ok;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(int stb, int code, int data, int done, int aend,
                                int wp, int busy, int addr, int op,
                                int st, int ok, int req);
        vec_t v;
        v.stb = 1'(stb);   v.code = 3'(code); v.data = 8'(data);
        v.done = 1'(done); v.aend = 1'(aend); v.wp_n = 1'(wp);
        v.busy = 1'(busy); v.addr = 19'(addr); v.op = 2'(op);
        v.exp_st = 8'(st); v.exp_ok = 1'(ok); v.req = 4'(req);
        return v;
    endfunction

    localparam int NV = 43;
    // codes: 0 other,1 wren,2 wrdi,3 ewsr,4 wrsr,5 aai begin; ops: 0 prog,1 sect,2 block,3 chip
    localparam vec_t VEC [0:NV-1] = '{
        mk(0,0,'h00,0,0,1,0,'h00000,0,'h0C,0,2),  // R2 idle after reset
        mk(1,1,'h00,0,0,1,0,'h00000,0,'h0E,0,9),  // R9 wren, full protection
        mk(1,4,'h00,0,0,1,0,'h00000,0,'h0E,0,3),  // R3 unarmed write
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h0E,0,3),  // R3 arm
        mk(1,4,'h04,0,0,1,0,'h5FFFF,0,'h06,1,6),  // R6 quarter, below floor
        mk(0,0,'h00,0,0,1,0,'h60000,0,'h06,0,6),  // R6 at floor
        mk(0,0,'h00,0,0,1,0,'h5F000,1,'h06,1,7),  // R7 sector below
        mk(0,0,'h00,0,0,1,0,'h60000,1,'h06,0,7),  // R7 sector inside
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h06,1,3),  // R3 arm
        mk(1,0,'h00,0,0,1,0,'h00000,0,'h06,1,3),  // R3 other wastes arm
        mk(1,4,'h08,0,0,1,0,'h00000,0,'h06,1,3),  // R3 rejected
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h06,1,3),
        mk(1,4,'h08,0,0,1,0,'h38000,2,'h0A,1,7),  // R7 half, block below
        mk(0,0,'h00,0,0,1,0,'h40000,2,'h0A,0,7),  // R7 block inside
        mk(0,0,'h00,0,0,1,0,'h00000,3,'h0A,0,8),  // R8 chip blocked
        mk(1,3,'h00,0,0,0,0,'h00000,3,'h0A,0,5),
        mk(1,4,'h80,0,0,0,0,'h00000,3,'h82,1,5),  // R5 lock + level in one write
        mk(1,3,'h00,0,0,0,0,'h00000,3,'h82,1,4),
        mk(1,4,'h0C,0,0,0,0,'h00000,3,'h82,1,4),  // R4 locked, rejected
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h82,1,4),
        mk(1,4,'h00,0,0,1,0,'h00000,0,'h02,1,4),  // R4 pin high unlocks
        mk(0,0,'h00,0,0,1,1,'h00000,0,'h03,0,11), // R11 busy blocks
        mk(1,3,'h00,0,0,1,1,'h00000,0,'h03,0,11),
        mk(1,4,'h01,0,0,1,1,'h00000,0,'h03,0,11), // R11 busy not writable
        mk(0,0,'h00,1,0,1,0,'h00000,0,'h00,0,9),  // R9 done clears wel
        mk(1,5,'h00,0,0,1,0,'h00000,0,'h00,0,10), // R10 no wel, no aai
        mk(1,1,'h00,0,0,1,0,'h00000,0,'h02,1,9),
        mk(1,5,'h00,0,0,1,0,'h00000,0,'h42,1,10), // R10 aai set
        mk(1,2,'h00,0,0,1,0,'h00000,0,'h00,0,10), // R10 wrdi clears
        mk(1,1,'h00,0,0,1,0,'h00000,0,'h02,1,9),
        mk(1,5,'h00,0,0,1,0,'h00000,0,'h42,1,10),
        mk(0,0,'h00,0,1,1,0,'h00000,0,'h00,0,10), // R10 top reached
        mk(1,1,'h00,1,0,1,0,'h00000,0,'h02,1,12), // R12 wren beats done
        mk(1,5,'h00,0,1,1,0,'h00000,0,'h40,0,12), // R12 aai begin over end
        mk(1,2,'h00,0,0,1,0,'h00000,0,'h00,0,10),
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h00,0,6),
        mk(1,4,'h0C,0,0,1,0,'h00000,0,'h0C,0,6),
        mk(1,1,'h00,0,0,1,0,'h00000,0,'h0E,0,6),
        mk(1,5,'h00,0,0,1,0,'h00000,0,'h0E,0,10), // R10 protected start
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h0E,0,1),
        mk(1,4,'hFF,0,0,1,0,'h00000,0,'h8E,0,1),  // R1 only bits 7,3,2 written
        mk(1,3,'h00,0,0,1,0,'h00000,0,'h8E,0,1),
        mk(1,4,'h00,0,0,1,0,'h00000,0,'h02,1,1)   // R1 layout back to clear
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_stb_i;
    logic [2:0]  instr_code_i;
    logic [7:0]  wrsr_data_i;
    logic        op_done_i;
    logic        aai_end_i;
    logic        busy_i;
    logic        wp_n_i;
    logic [18:0] chk_addr_i;
    logic [1:0]  chk_op_i;
    logic [7:0]  status_o;
    logic        write_ok_o;
    logic        aai_mode_o;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    flash_status_guard u0 (
        .clk          (clk),
        .rst          (rst),
        .instr_stb_i  (instr_stb_i),
        .instr_code_i (instr_code_i),
        .wrsr_data_i  (wrsr_data_i),
        .op_done_i    (op_done_i),
        .aai_end_i    (aai_end_i),
        .busy_i       (busy_i),
        .wp_n_i       (wp_n_i),
        .chk_addr_i   (chk_addr_i),
        .chk_op_i     (chk_op_i),
        .status_o     (status_o),
        .write_ok_o   (write_ok_o),
        .aai_mode_o   (aai_mode_o)
    );

    task automatic check(string tag, logic [7:0] exp_st, logic exp_ok);
        checks++;
        if (status_o !== exp_st || write_ok_o !== exp_ok || aai_mode_o !== exp_st[6]) begin
            fails++;
            $display("FAIL %s: status=%02h ok=%0b aai=%0b expected status=%02h ok=%0b aai=%0b",
                     tag, status_o, write_ok_o, aai_mode_o, exp_st, exp_ok, exp_st[6]);
        end
    endtask

    task automatic drop_strobes();
        instr_stb_i = 1'b0;
        op_done_i   = 1'b0;
        aai_end_i   = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        drop_strobes();
        instr_code_i = 3'd0;
        wrsr_data_i  = 8'h00;
        busy_i       = 1'b0;
        wp_n_i       = 1'b1;
        chk_addr_i   = '0;
        chk_op_i     = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R2 reset", 8'h0C, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr_stb_i  = VEC[i].stb;
            instr_code_i = VEC[i].code;
            wrsr_data_i  = VEC[i].data;
            op_done_i    = VEC[i].done;
            aai_end_i    = VEC[i].aend;
            wp_n_i       = VEC[i].wp_n;
            busy_i       = VEC[i].busy;
            chk_addr_i   = VEC[i].addr;
            chk_op_i     = VEC[i].op;
            @(negedge clk);
            drop_strobes();
            #1;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_st, VEC[i].exp_ok);
        end

        // R2: reset mid-run restores defaults
        @(negedge clk);
        instr_stb_i = 1'b1; instr_code_i = 3'd1;
        @(negedge clk);
        drop_strobes();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R2 reset after wren", 8'h0C, 1'b0);

        // R11: busy shows through bit 0 immediately
        busy_i = 1'b1;
        #1;
        check("R11 busy bit", 8'h0D, 1'b0);
        busy_i = 1'b0;

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule